// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked request port and an external asynchronous static RAM of 128K bytes. The RAM has two chip selects of opposite polarity (one active low, one active high), an active-low output enable and an active-low write enable. The controller turns a single-cycle request into a correctly shaped strobe sequence on those pins. The bidirectional data bus is split into an output, an input and a driver-enable.

All memory timing limits are given as nanosecond parameters, together with the clock period. The block derives from them, at elaboration, the number of clock cycles for the read access, the write pulse and the bus turnaround after a read. Each count is the ceiling of the time divided by the period, and never less than one cycle. A user issues a request only while `ready` is high. Completion is signalled by a one-cycle `done` pulse, and for reads the captured byte appears on `rdata` in that same cycle.

Top module: `sram_ctl`

## Requirements
- R1: After reset and whenever no access is in progress, the memory pins are deselected: mem_cs1_n=1, mem_cs2=0, mem_oe_n=1, mem_we_n=1, mem_drv=0. In that state done=0 and ready=1.
- R2: A read is accepted at a clock edge where req=1 and ready=1 with req_we=0. For the next NRD cycles the pins are mem_cs1_n=0, mem_cs2=1, mem_oe_n=0, mem_we_n=1, mem_drv=0. NRD = max(ceil(T_AA/CLK), ceil(T_RC/CLK), ceil(T_OE/CLK)), at least 1, which is 4 at the defaults. mem_din is sampled at the edge that ends the last of these cycles.
- R3: A write (req_we=1) begins with exactly one setup cycle and ends with exactly one recovery cycle. In both, the chip is selected (mem_cs1_n=0, mem_cs2=1), mem_oe_n=1, mem_we_n=1 and mem_drv=1, so the address and data are present before the write enable falls and remain after it rises.
- R4: Between the setup and recovery cycles, mem_we_n=0 for NWP cycles, with the chip selected and mem_drv=1. NWP is the largest of ceil(T_WP/CLK), ceil(T_CW/CLK)-1, ceil(T_AW/CLK)-1, ceil(T_DW/CLK)-1, ceil(T_WC/CLK)-2 and 1, which is 3 at the defaults.
- R5: mem_drv is high only during the cycles of a write and never while mem_oe_n=0. While mem_drv is high, mem_dout carries the accepted write data.
- R6: After the last read cycle, NTA = ceil(T_HZ/CLK) cycles follow, at least 1 (2 at the defaults). In these cycles the pins are deselected, ready=0 and mem_drv=0. Only after them can the next request be accepted.
- R7: done is high for exactly one cycle, the cycle right after the last strobe cycle of an access. After a read, rdata holds the byte the memory returned, and it keeps that value until the next read completes.
- R8: ready is high only when idle. A request presented while ready=0 is ignored: the strobes, the address and the memory contents are unchanged.
- R9: mem_addr equals the accepted address throughout an access, and it changes only while the chip is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Access request, taken while ready is high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address of the access |
| req_wdata | input | 8 | Byte to write |
| ready | output | 1 | Controller idle, request will be accepted |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last byte read |
| mem_addr | output | 17 | Memory address bus |
| mem_cs1_n | output | 1 | Chip select, active low |
| mem_cs2 | output | 1 | Chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dout | output | 8 | Data toward the memory |
| mem_din | input | 8 | Data from the memory |
| mem_drv | output | 1 | Enable for the controller's data driver |

## Verification
The strobes and the address change one cycle after the accepting edge. A read's done and rdata are due one cycle after the NRD-th access cycle. ready returns NTA cycles after that for reads, and in the done cycle itself for writes. At each accepting edge the bench builds, from its own cycle-count arithmetic, a queue holding the expected pin pattern of every following cycle. It pops one entry per rising edge and compares all outputs at the falling edge, so each result is checked in exactly the cycle it is due. A behavioural memory in the bench stores bytes while the write window is open and returns them while the output enable is low, which lets read-back values and ignored requests be judged at the ports.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_TURN = 3'd2,
    ST_WSET = 3'd3,
    ST_WPUL = 3'd4,
    ST_WREC = 3'd5
  } state_t;

  typedef struct packed {
    logic cs1_n;
    logic cs2;
    logic oe_n;
    logic we_n;
    logic drv;
  } strobe_t;

  // ceiling of ns/clk_ns, never below one cycle
  function automatic int cycles_for(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int read_cycles(input int aa, input int rc, input int oe, input int clk_ns);
    return max2(cycles_for(aa, clk_ns), max2(cycles_for(rc, clk_ns), cycles_for(oe, clk_ns)));
  endfunction

  // the pulse is framed by one setup and one recovery cycle, with chip select held over both
  function automatic int pulse_cycles(input int wp, input int cw, input int aw, input int dw,
                                      input int wc, input int clk_ns);
    int p;
    p = cycles_for(wp, clk_ns);
    p = max2(p, cycles_for(cw, clk_ns) - 1);
    p = max2(p, cycles_for(aw, clk_ns) - 1);
    p = max2(p, cycles_for(dw, clk_ns) - 1);
    p = max2(p, cycles_for(wc, clk_ns) - 2);
    return max2(p, 1);
  endfunction

  function automatic strobe_t strobes_for(input state_t s);
    strobe_t o;
    o = '{cs1_n: 1'b1, cs2: 1'b0, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};
    case (s)
      ST_RD:   o = '{cs1_n: 1'b0, cs2: 1'b1, oe_n: 1'b0, we_n: 1'b1, drv: 1'b0};
      ST_WSET: o = '{cs1_n: 1'b0, cs2: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b1};
      ST_WPUL: o = '{cs1_n: 1'b0, cs2: 1'b1, oe_n: 1'b1, we_n: 1'b0, drv: 1'b1};
      ST_WREC: o = '{cs1_n: 1'b0, cs2: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b1};
      default: o = '{cs1_n: 1'b1, cs2: 1'b0, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};
    endcase
    return o;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R4: a loaded count is the one the sequencer asked for
  a_r4_load_taken: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter int N_RD  = 4,
  parameter int N_WP  = 3,
  parameter int N_TA  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_we,
  input  logic             zero,
  output state_t           state_q,
  output state_t           state_d,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             accept,
  output logic             rd_capture,
  output logic             wr_finish,
  output logic             ready
);

  localparam logic [CNT_W-1:0] LD_RD = CNT_W'(N_RD - 1);
  localparam logic [CNT_W-1:0] LD_WP = CNT_W'(N_WP - 1);
  localparam logic [CNT_W-1:0] LD_TA = CNT_W'(N_TA - 1);

  assign ready      = (state_q == ST_IDLE);
  assign accept     = ready && req;
  assign rd_capture = (state_q == ST_RD) && zero;
  assign wr_finish  = (state_q == ST_WREC);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (req) state_d = req_we ? ST_WSET : ST_RD;
      ST_RD:   if (zero) state_d = ST_TURN;
      ST_TURN: if (zero) state_d = ST_IDLE;
      ST_WSET: state_d = ST_WPUL;
      ST_WPUL: if (zero) state_d = ST_WREC;
      ST_WREC: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    load     = 1'b0;
    load_val = '0;
    if (state_d != state_q) begin
      case (state_d)
        ST_RD:   begin load = 1'b1; load_val = LD_RD; end
        ST_TURN: begin load = 1'b1; load_val = LD_TA; end
        ST_WPUL: begin load = 1'b1; load_val = LD_WP; end
        default: begin load = 1'b0; load_val = '0;    end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R8: once a request is taken the port is busy on the next cycle
  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);

  // R6: the turnaround is only entered from a read capture
  a_r6_turn_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_TURN) |-> $past(rd_capture));

endmodule

// File: rtl/sram_ctl_datapath.sv
module sram_ctl_datapath
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              rd_capture,
  input  logic              wr_finish,
  input  state_t            state_d,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_din,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output strobe_t           strb,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_dout <= '0;
    end else if (accept) begin
      mem_addr <= req_addr;
      mem_dout <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb <= strobes_for(ST_IDLE);
    else        strb <= strobes_for(state_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      done  <= 1'b0;
    end else begin
      done <= rd_capture || wr_finish;
      if (rd_capture) rdata <= mem_din;
    end
  end

  // R3: the write enable is low only while the chip is selected and data is driven
  a_r3_we_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.we_n |-> (!strb.cs1_n && strb.cs2 && strb.drv));

  // R3: chip select is released only after the write enable has risen
  a_r3_we_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strb.cs1_n) |-> $past(strb.we_n));

  // R9: the address does not move while the chip stays selected
  a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.cs1_n && $past(!strb.cs1_n)) |-> $stable(mem_addr));

  // R7: completion is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 20,
  parameter int T_RC_NS = 70,
  parameter int T_AA_NS = 70,
  parameter int T_OE_NS = 35,
  parameter int T_WC_NS = 70,
  parameter int T_WP_NS = 55,
  parameter int T_CW_NS = 60,
  parameter int T_AW_NS = 60,
  parameter int T_DW_NS = 30,
  parameter int T_HZ_NS = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs1_n,
  output logic              mem_cs2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dout,
  input  logic [DATA_W-1:0] mem_din,
  output logic              mem_drv
);

  localparam int N_RD  = read_cycles(T_AA_NS, T_RC_NS, T_OE_NS, CLK_NS);
  localparam int N_WP  = pulse_cycles(T_WP_NS, T_CW_NS, T_AW_NS, T_DW_NS, T_WC_NS, CLK_NS);
  localparam int N_TA  = cycles_for(T_HZ_NS, CLK_NS);
  localparam int N_MAX = max2(N_RD, max2(N_WP, N_TA));
  localparam int CNT_W = max2(1, $clog2(N_MAX + 1));

  state_t           state_q;
  state_t           state_d;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             zero;
  logic             accept;
  logic             rd_capture;
  logic             wr_finish;
  strobe_t          strb;

  sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .zero     (zero)
  );

  sram_ctl_seq #(
    .CNT_W (CNT_W),
    .N_RD  (N_RD),
    .N_WP  (N_WP),
    .N_TA  (N_TA)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .req_we     (req_we),
    .zero       (zero),
    .state_q    (state_q),
    .state_d    (state_d),
    .load       (load),
    .load_val   (load_val),
    .accept     (accept),
    .rd_capture (rd_capture),
    .wr_finish  (wr_finish),
    .ready      (ready)
  );

  sram_ctl_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .rd_capture (rd_capture),
    .wr_finish  (wr_finish),
    .state_d    (state_d),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_din    (mem_din),
    .mem_addr   (mem_addr),
    .mem_dout   (mem_dout),
    .strb       (strb),
    .rdata      (rdata),
    .done       (done)
  );

  assign mem_cs1_n = strb.cs1_n;
  assign mem_cs2   = strb.cs2;
  assign mem_oe_n  = strb.oe_n;
  assign mem_we_n  = strb.we_n;
  assign mem_drv   = strb.drv;

  // R5: the controller never drives while the memory output is enabled
  a_r5_no_fight: assert property (@(posedge clk) disable iff (!rst_n)
    mem_drv |-> mem_oe_n);

  // R6: driver turn-on never directly follows an enabled memory output
  a_r6_drive_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_drv) |-> $past(mem_oe_n));

  // R1: the pins leave the deselected state only through an accepted request
  a_r1_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ready) && !$past(req)) |-> (mem_cs1_n && !mem_cs2 && !mem_drv));

endmodule

// File: tb/tb_sram_ctl.sv
module tb_sram_ctl;

  localparam int CLK = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        req_we = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        ready, done;
  logic [7:0]  rdata;
  logic [16:0] mem_addr;
  logic        mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_drv;
  logic [7:0]  mem_dout;
  logic [7:0]  mem_din = 8'h00;

  always #(CLK/2) clk = ~clk;

  sram_ctl dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .ready(ready), .done(done), .rdata(rdata),
    .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dout(mem_dout),
    .mem_din(mem_din), .mem_drv(mem_drv)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle counts restated by counting periods upward
  function automatic int ncyc(input int ns);
    int n = 0;
    while (n * CLK < ns) n++;
    if (n == 0) n = 1;
    return n;
  endfunction

  int n_rd, n_wp, n_ta;
  initial begin
    n_rd = ncyc(70);
    if (ncyc(70) > n_rd) n_rd = ncyc(70);
    if (ncyc(35) > n_rd) n_rd = ncyc(35);
    n_wp = ncyc(55);
    if (ncyc(60) - 1 > n_wp) n_wp = ncyc(60) - 1;
    if (ncyc(30) - 1 > n_wp) n_wp = ncyc(30) - 1;
    if (ncyc(70) - 2 > n_wp) n_wp = ncyc(70) - 2;
    n_ta = ncyc(25);
  end

  typedef struct {
    bit    cs1_n, cs2, oe_n, we_n, drv, dn, rdy;
    string tag;
  } pat_t;

  pat_t q[$];
  pat_t cur;
  bit [7:0] mem_m [int];
  logic [16:0] exp_addr = '0;
  logic [7:0]  exp_wdata = '0;
  logic [7:0]  exp_rdata = '0;
  bit          cur_is_read = 1'b0;
  bit          pend_read = 1'b0;

  function automatic pat_t mk(input bit c1, input bit c2, input bit oe, input bit we,
                              input bit dv, input bit dn, input bit rdy, input string tag);
    pat_t p;
    p.cs1_n = c1; p.cs2 = c2; p.oe_n = oe; p.we_n = we;
    p.drv = dv; p.dn = dn; p.rdy = rdy; p.tag = tag;
    return p;
  endfunction

  function automatic bit [7:0] mem_val(input logic [16:0] a);
    if (mem_m.exists(int'(a))) return mem_m[int'(a)];
    return 8'hA5 ^ a[7:0];
  endfunction

  initial cur = mk(1, 0, 1, 1, 0, 0, 1, "R1");

  // reference schedule: advanced once per rising edge
  always @(posedge clk) begin
    if (rst_n) begin
      if (cur.rdy && req) begin
        exp_addr  = req_addr;
        exp_wdata = req_wdata;
        if (req_we) begin
          q.push_back(mk(0, 1, 1, 1, 1, 0, 0, "R3"));
          for (int i = 0; i < n_wp; i++) q.push_back(mk(0, 1, 1, 0, 1, 0, 0, "R4"));
          q.push_back(mk(0, 1, 1, 1, 1, 0, 0, "R3"));
          q.push_back(mk(1, 0, 1, 1, 0, 1, 1, "R7"));
          pend_read = 1'b0;
        end else begin
          exp_rdata = mem_val(req_addr);
          for (int i = 0; i < n_rd; i++) q.push_back(mk(0, 1, 0, 1, 0, 0, 0, "R2"));
          for (int i = 0; i < n_ta; i++)
            q.push_back(mk(1, 0, 1, 1, 0, (i == 0), 0, "R6"));
          pend_read = 1'b1;
        end
      end
      if (q.size() > 0) cur = q.pop_front();
      else              cur = mk(1, 0, 1, 1, 0, 0, 1, "R1");
      cur_is_read = pend_read && cur.dn;
    end
  end

  logic [7:0] held_rdata = 8'h00;

  // compare at the falling edge, and model the memory there
  always @(negedge clk) begin
    if (rst_n) begin
      chk(mem_cs1_n == cur.cs1_n, {cur.tag, " cs1_n"}, mem_cs1_n, cur.cs1_n);
      chk(mem_cs2   == cur.cs2,   {cur.tag, " cs2"},   mem_cs2,   cur.cs2);
      chk(mem_oe_n  == cur.oe_n,  {cur.tag, " oe_n"},  mem_oe_n,  cur.oe_n);
      chk(mem_we_n  == cur.we_n,  {cur.tag, " we_n"},  mem_we_n,  cur.we_n);
      chk(mem_drv   == cur.drv,   "R5 drv",            mem_drv,   cur.drv);
      chk(done      == cur.dn,    "R7 done",           done,      cur.dn);
      chk(ready     == cur.rdy,   "R8 ready",          ready,     cur.rdy);
      if (!cur.cs1_n) chk(mem_addr == exp_addr, "R9 addr", mem_addr, exp_addr);
      if (cur.drv)    chk(mem_dout == exp_wdata, "R5 dout", mem_dout, exp_wdata);
      if (cur_is_read) held_rdata = exp_rdata;
      chk(rdata == held_rdata, "R7 rdata", rdata, held_rdata);
      if (!mem_cs1_n && mem_cs2 && !mem_we_n) mem_m[int'(mem_addr)] = mem_dout;
      if (!mem_cs1_n && mem_cs2 && !mem_oe_n && mem_we_n) mem_din <= mem_val(mem_addr);
      else mem_din <= 8'h3C;
    end
  end

  task automatic access(input bit we, input logic [16:0] a, input logic [7:0] d);
    while (!ready) @(negedge clk);
    req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic settle();
    while (!ready || done) @(negedge clk);
    @(negedge clk);
  endtask

  bit finished = 1'b0;

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 100000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values, before the model starts
    chk(mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n && !mem_drv, "R1 reset pins",
        {mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_drv}, 5'b10110);
    chk(ready && !done, "R1 reset ready", {ready, done}, 2'b10);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // writes, including the top address and back-to-back writes
    access(1, 17'h00010, 8'h3C);
    access(1, 17'h1FFFF, 8'hC3);
    access(1, 17'h00000, 8'hFF);
    settle();
    // R2/R7: read back and read an unwritten location
    access(0, 17'h00010, 8'h00);
    access(0, 17'h1FFFF, 8'h00);
    access(0, 17'h00000, 8'h00);
    access(0, 17'h0ABCD, 8'h00);
    // R6: write right after a read
    access(1, 17'h00123, 8'h5A);
    access(0, 17'h00123, 8'h00);
    settle();
    // R8: request while busy must be ignored
    access(0, 17'h00010, 8'h00);
    req = 1'b1; req_we = 1'b1; req_addr = 17'h00055; req_wdata = 8'h77;
    repeat (2) @(negedge clk);
    req = 1'b0;
    settle();
    access(0, 17'h00055, 8'h00);
    settle();
    chk(mem_val(17'h00055) == (8'hA5 ^ 8'h55), "R8 ignored write",
        mem_val(17'h00055), 8'hA5 ^ 8'h55);
    chk(rdata == (8'hA5 ^ 8'h55), "R8 ignored readback", rdata, 8'hA5 ^ 8'h55);
    chk(mem_val(17'h1FFFF) == 8'hC3, "R4 top address stored", mem_val(17'h1FFFF), 8'hC3);
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R1 schedule drained", q.size(), 0);
    finish_run();
  end

endmodule